// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block tracks the fetch condition of every hardware thread in a multithreaded fetch stage. In each clock cycle it takes in stall and release pulses from the four downstream stages, redirect requests from the commit and decode stages, a "reorder buffer still flushing" hint, instruction-cache handshake events, fetch faults and quiesce events. From these it computes the next condition of each thread under a fixed priority.

For each thread it drives a registered status code, a one-cycle pulse that marks a status change, and a redirect indication. The redirect indication carries the new fetch address and says whether commit or decode asked for it. A single stage-active flag tells the surrounding core whether any participating thread can still make progress. The fetch datapath reads the status to decide which threads may issue cache requests. The core reads the stage-active flag to decide whether the stage can be clock-gated.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread reports Running (code 0), no redirect and no change pulse, and no stall flag is set. Status codes are Running 0, Idle 1, Squashing 2, Blocked 3, TrapPending 4, QuiescePending 5, WaitResponse 6, WaitRetry 7, LineReady 8. The code of thread t sits at bits [4t+3:4t].
- R2: Each thread keeps one sticky stall flag per downstream source, at bit t*NUM_STALL_SRC+s. The sources are decode (s=0), rename (s=1), execute (s=2) and commit (s=3). A set pulse raises the flag and a clear pulse lowers it. The flag holds between pulses. A clear pulse is only legal while the flag is set and while no set pulse arrives for the same flag.
- R3: A commit redirect beats every other input. The thread goes to Squashing from any state. In the next cycle redirect_valid is 1, redirect_from_commit is 1, and redirect_pc equals the commit address.
- R4: Without a commit redirect, the reorder-buffer flushing hint puts or keeps the thread in Squashing and raises no redirect.
- R5: A decode redirect is applied only when the thread is not already Squashing. It then gives Squashing with redirect_valid 1, redirect_from_commit 0 and the decode address. While the thread is Squashing the decode redirect is ignored.
- R6: A thread becomes Blocked if any of its stall flags is set after this cycle's pulses, or if the global context-switch stall is high. A thread in WaitResponse or WaitRetry keeps its state.
- R7: A Blocked or Squashing thread with no redirect, no flushing hint and no stall returns to Running.
- R8: A line fill in WaitResponse gives Blocked if the thread is stalled and LineReady otherwise. A line fill in any other state is ignored.
- R9: A thread in LineReady becomes Running on a fetch attempt. A Running thread moves to WaitRetry on a refused request, and to WaitResponse on an accepted one; a refusal wins. A thread in WaitRetry moves to WaitResponse when its retry is accepted.
- R10: A Running thread goes to TrapPending on a fetch fault and to QuiescePending on a quiesce event; the fault wins. Both states hold until a redirect or a stall.
- R11: stage_active is 1 exactly when some thread whose thread_active bit is set is in Running, Squashing or LineReady.
- R12: state_changed of a thread is 1 for exactly the one cycle in which its status output shows a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active | input | NUM_THREADS | Threads that count toward stage_active |
| ctx_switch_stall | input | 1 | Global stall that blocks all threads |
| stall_set | input | NUM_THREADS*NUM_STALL_SRC | Stall-raise pulses, bit t*NUM_STALL_SRC+s |
| stall_clr | input | NUM_THREADS*NUM_STALL_SRC | Stall-release pulses, same layout |
| commit_squash | input | NUM_THREADS | Commit redirect request |
| commit_pc | input | NUM_THREADS*PC_W | Commit redirect address per thread |
| rob_flushing | input | NUM_THREADS | Reorder buffer still flushing |
| decode_squash | input | NUM_THREADS | Decode redirect request |
| decode_pc | input | NUM_THREADS*PC_W | Decode redirect address per thread |
| line_fill | input | NUM_THREADS | Instruction-cache response arrived |
| fetch_go | input | NUM_THREADS | Fetch attempt on this thread |
| req_sent | input | NUM_THREADS | Cache request accepted |
| req_nack | input | NUM_THREADS | Cache request refused |
| retry_sent | input | NUM_THREADS | Refused request accepted on retry |
| fetch_fault | input | NUM_THREADS | Fetch translation fault |
| quiesce_hit | input | NUM_THREADS | Quiesce event fetched |
| thread_state | output | NUM_THREADS*4 | Status code per thread |
| state_changed | output | NUM_THREADS | One-cycle status change pulse |
| redirect_valid | output | NUM_THREADS | Redirect taken last edge |
| redirect_pc | output | NUM_THREADS*PC_W | Address of the last redirect |
| redirect_from_commit | output | NUM_THREADS | 1 if the last redirect came from commit |
| stage_active | output | 1 | Some active thread can progress |

## Verification
The bench uses the defaults: two threads, 32-bit addresses, four stall sources and a combinational stage-active flag. With two threads it can show that one thread's events leave the other untouched. It can also let commit and decode redirects arrive at the same edge on different threads, and it can drop a thread out of the active mask so that the stage-active reduction has to tell the participating threads from the others. Four stall sources give enough overlapping stalls to show that a thread stays Blocked until the last flag clears.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

   localparam int STATE_W = 4;

   typedef enum logic [STATE_W-1:0] {
      TS_RUN        = 4'd0,
      TS_IDLE       = 4'd1,
      TS_SQUASH     = 4'd2,
      TS_BLOCKED    = 4'd3,
      TS_TRAP       = 4'd4,
      TS_QUIESCE    = 4'd5,
      TS_WAIT_RESP  = 4'd6,
      TS_WAIT_RETRY = 4'd7,
      TS_LINE_READY = 4'd8
   } thr_state_e;

endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags #(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_pulse,
   input  logic [NUM_SRC-1:0] clr_pulse,
   output logic               any_now
);

   logic [NUM_SRC-1:0] flags_q;
   logic [NUM_SRC-1:0] flags_d;

   // a set wins over a clear; the pair is illegal anyway
   always_comb begin
      flags_d = (flags_q & ~clr_pulse) | set_pulse;
      any_now = |flags_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
      AST_CLEAR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
         clr_pulse[s] |-> (flags_q[s] && !set_pulse[s])); // R2
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_q[s] && !clr_pulse[s]) |=> flags_q[s]); // R2
      AST_FLAG_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
         set_pulse[s] |=> flags_q[s]); // R2
   end

endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
   import fsc_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            stalled,
   input  logic            cmt_sq,
   input  logic [PC_W-1:0] cmt_pc,
   input  logic            rob_sq,
   input  logic            dec_sq,
   input  logic [PC_W-1:0] dec_pc,
   input  logic            line_fill,
   input  logic            fetch_go,
   input  logic            req_sent,
   input  logic            req_nack,
   input  logic            retry_sent,
   input  logic            fetch_fault,
   input  logic            quiesce_hit,
   output thr_state_e      state,
   output logic            changed,
   output logic            redir_valid,
   output logic [PC_W-1:0] redir_pc,
   output logic            redir_from_commit
);

   thr_state_e      state_q, state_d;
   logic            changed_q;
   logic            redir_q, redir_d;
   logic [PC_W-1:0] pc_q, pc_d;
   logic            src_q, src_d;
   logic            waiting;

   assign waiting = (state_q == TS_WAIT_RESP) || (state_q == TS_WAIT_RETRY);

   always_comb begin
      state_d = state_q;
      redir_d = 1'b0;
      pc_d    = pc_q;
      src_d   = src_q;
      if (cmt_sq) begin
         state_d = TS_SQUASH;
         redir_d = 1'b1;
         pc_d    = cmt_pc;
         src_d   = 1'b1;
      end else if (rob_sq) begin
         state_d = TS_SQUASH;
      end else if (dec_sq && state_q != TS_SQUASH) begin
         state_d = TS_SQUASH;
         redir_d = 1'b1;
         pc_d    = dec_pc;
         src_d   = 1'b0;
      end else if (stalled && !waiting) begin
         state_d = TS_BLOCKED;
      end else if (state_q == TS_BLOCKED || state_q == TS_SQUASH) begin
         state_d = TS_RUN;
      end else begin
         case (state_q)
            TS_RUN: begin
               if (fetch_fault)      state_d = TS_TRAP;
               else if (quiesce_hit) state_d = TS_QUIESCE;
               else if (req_nack)    state_d = TS_WAIT_RETRY;
               else if (req_sent)    state_d = TS_WAIT_RESP;
            end
            TS_WAIT_RESP: begin
               if (line_fill) state_d = stalled ? TS_BLOCKED : TS_LINE_READY;
            end
            TS_WAIT_RETRY: begin
               if (retry_sent) state_d = TS_WAIT_RESP;
            end
            TS_LINE_READY: begin
               if (fetch_go) state_d = TS_RUN;
            end
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= TS_RUN;
         changed_q <= 1'b0;
         redir_q   <= 1'b0;
         pc_q      <= '0;
         src_q     <= 1'b0;
      end else begin
         state_q   <= state_d;
         changed_q <= (state_d != state_q);
         redir_q   <= redir_d;
         pc_q      <= pc_d;
         src_q     <= src_d;
      end
   end

   assign state             = state_q;
   assign changed           = changed_q;
   assign redir_valid       = redir_q;
   assign redir_pc          = pc_q;
   assign redir_from_commit = src_q;

   AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_sq |=> (state_q == TS_SQUASH && redir_q && src_q && pc_q == $past(cmt_pc))); // R3
   AST_FLUSH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rob_sq && !cmt_sq) |=> (state_q == TS_SQUASH && !redir_q)); // R4
   AST_DECODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_sq && !cmt_sq && state_q == TS_SQUASH) |=> !redir_q); // R5
   AST_RETRY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (stalled && state_q == TS_WAIT_RETRY && !cmt_sq && !rob_sq && !dec_sq && !retry_sent)
      |=> state_q == TS_WAIT_RETRY); // R6
   AST_FILL_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
      (line_fill && state_q == TS_RUN && !cmt_sq && !rob_sq && !dec_sq && !stalled)
      |=> state_q != TS_LINE_READY); // R8
   AST_CHANGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      changed_q == (state_q != $past(state_q))); // R12

endmodule

// File: rtl/fsc_stage_activity.sv
module fsc_stage_activity
   import fsc_pkg::*;
#(
   parameter int NUM_THREADS = 2,
   parameter bit REGISTERED  = 1'b0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_THREADS-1:0]         thread_active,
   input  logic [NUM_THREADS*STATE_W-1:0] state_flat,
   output logic                           active
);

   logic [NUM_THREADS-1:0] can_go;
   logic                   any_go;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      thr_state_e st;
      assign st = thr_state_e'(state_flat[t*STATE_W +: STATE_W]);
      assign can_go[t] = thread_active[t] &&
                         (st == TS_RUN || st == TS_SQUASH || st == TS_LINE_READY);
   end

   assign any_go = |can_go;

   if (REGISTERED) begin : g_reg
      logic active_q;
      always_ff @(posedge clk) begin
         if (!rst_n) active_q <= 1'b0;
         else        active_q <= any_go;
      end
      assign active = active_q;
      AST_IDLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
         (thread_active == '0) |=> !active); // R11
   end else begin : g_comb
      assign active = any_go;
      AST_IDLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
         (thread_active == '0) |-> !active); // R11
   end

endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
   import fsc_pkg::*;
#(
   parameter int NUM_THREADS       = 2,
   parameter int PC_W              = 32,
   parameter int NUM_STALL_SRC     = 4,
   parameter bit ACTIVE_REGISTERED = 1'b0
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_THREADS-1:0]             thread_active,
   input  logic                               ctx_switch_stall,
   input  logic [NUM_THREADS*NUM_STALL_SRC-1:0] stall_set,
   input  logic [NUM_THREADS*NUM_STALL_SRC-1:0] stall_clr,
   input  logic [NUM_THREADS-1:0]             commit_squash,
   input  logic [NUM_THREADS*PC_W-1:0]        commit_pc,
   input  logic [NUM_THREADS-1:0]             rob_flushing,
   input  logic [NUM_THREADS-1:0]             decode_squash,
   input  logic [NUM_THREADS*PC_W-1:0]        decode_pc,
   input  logic [NUM_THREADS-1:0]             line_fill,
   input  logic [NUM_THREADS-1:0]             fetch_go,
   input  logic [NUM_THREADS-1:0]             req_sent,
   input  logic [NUM_THREADS-1:0]             req_nack,
   input  logic [NUM_THREADS-1:0]             retry_sent,
   input  logic [NUM_THREADS-1:0]             fetch_fault,
   input  logic [NUM_THREADS-1:0]             quiesce_hit,
   output logic [NUM_THREADS*STATE_W-1:0]     thread_state,
   output logic [NUM_THREADS-1:0]             state_changed,
   output logic [NUM_THREADS-1:0]             redirect_valid,
   output logic [NUM_THREADS*PC_W-1:0]        redirect_pc,
   output logic [NUM_THREADS-1:0]             redirect_from_commit,
   output logic                               stage_active
);

   localparam int NS = NUM_STALL_SRC;
   localparam int SW = STATE_W;

   if (NUM_THREADS < 1 || NUM_THREADS > 16) begin : g_bad_threads
      $error("fetch_status_ctrl: NUM_THREADS must lie in 1..16");
   end
   if (PC_W < 8 || PC_W > 64) begin : g_bad_pc
      $error("fetch_status_ctrl: PC_W must lie in 8..64");
   end
   if (NUM_STALL_SRC < 1 || NUM_STALL_SRC > 8) begin : g_bad_src
      $error("fetch_status_ctrl: NUM_STALL_SRC must lie in 1..8");
   end

   logic [NUM_THREADS-1:0] stall_any;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
      thr_state_e st;

      fsc_stall_flags #(.NUM_SRC(NS)) u_flags (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_pulse (stall_set[t*NS +: NS]),
         .clr_pulse (stall_clr[t*NS +: NS]),
         .any_now   (stall_any[t])
      );

      fsc_thread_fsm #(.PC_W(PC_W)) u_fsm (
         .clk               (clk),
         .rst_n             (rst_n),
         .stalled           (stall_any[t] | ctx_switch_stall),
         .cmt_sq            (commit_squash[t]),
         .cmt_pc            (commit_pc[t*PC_W +: PC_W]),
         .rob_sq            (rob_flushing[t]),
         .dec_sq            (decode_squash[t]),
         .dec_pc            (decode_pc[t*PC_W +: PC_W]),
         .line_fill         (line_fill[t]),
         .fetch_go          (fetch_go[t]),
         .req_sent          (req_sent[t]),
         .req_nack          (req_nack[t]),
         .retry_sent        (retry_sent[t]),
         .fetch_fault       (fetch_fault[t]),
         .quiesce_hit       (quiesce_hit[t]),
         .state             (st),
         .changed           (state_changed[t]),
         .redir_valid       (redirect_valid[t]),
         .redir_pc          (redirect_pc[t*PC_W +: PC_W]),
         .redir_from_commit (redirect_from_commit[t])
      );

      assign thread_state[t*SW +: SW] = st;

      AST_BLOCKED_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
         (ctx_switch_stall && !commit_squash[t] && !rob_flushing[t] && !decode_squash[t]
          && st == TS_RUN) |=> thread_state[t*SW +: SW] == TS_BLOCKED); // R6
   end

   fsc_stage_activity #(
      .NUM_THREADS (NUM_THREADS),
      .REGISTERED  (ACTIVE_REGISTERED)
   ) u_activity (
      .clk           (clk),
      .rst_n         (rst_n),
      .thread_active (thread_active),
      .state_flat    (thread_state),
      .active        (stage_active)
   );

endmodule

// File: tb/fetch_status_ctrl_test.sv
module fetch_status_ctrl_test;

   localparam int NT = 2;
   localparam int PW = 32;
   localparam int NS = 4;

   // vector layout: [22] redirect expected, [21:18] set, [17:14] clear,
   // [13] commit, [12] flush, [11] decode, [10] fill, [9] go, [8] sent,
   // [7] nack, [6] retry, [5] fault, [4] quiesce, [3:0] expected status
   localparam logic [22:0] X_RD  = 23'h400000;
   localparam logic [22:0] B_DEC = 23'h040000, B_REN = 23'h080000;
   localparam logic [22:0] B_EXE = 23'h100000, B_CMT = 23'h200000;
   localparam logic [22:0] U_DEC = 23'h004000, U_REN = 23'h008000;
   localparam logic [22:0] U_EXE = 23'h010000, U_CMT = 23'h020000;
   localparam logic [22:0] CSQ = 23'h002000, ROB = 23'h001000, DSQ = 23'h000800;
   localparam logic [22:0] FIL = 23'h000400, GO  = 23'h000200, SNT = 23'h000100;
   localparam logic [22:0] NAK = 23'h000080, RTY = 23'h000040;
   localparam logic [22:0] FLT = 23'h000020, QUI = 23'h000010;
   localparam logic [22:0] E_RUN = 23'd0, E_SQ = 23'd2, E_BLK = 23'd3, E_TRAP = 23'd4;
   localparam logic [22:0] E_QUI = 23'd5, E_WR = 23'd6, E_WT = 23'd7, E_LR = 23'd8;

   localparam int NV = 29;
   localparam logic [22:0] VECS [NV] = '{
      E_RUN,               SNT | E_WR,          B_DEC | E_WR,
      FIL | E_BLK,         E_BLK,               U_DEC | E_RUN,
      SNT | E_WR,          FIL | E_LR,          E_LR,
      GO | E_RUN,          NAK | E_WT,          FIL | E_WT,
      RTY | E_WR,          CSQ | X_RD | E_SQ,   FIL | E_RUN,
      DSQ | X_RD | E_SQ,   ROB | E_SQ,          ROB | DSQ | E_SQ,
      E_RUN,               FLT | QUI | E_TRAP,  E_TRAP,
      DSQ | X_RD | E_SQ,   E_RUN,               QUI | E_QUI,
      B_REN | B_EXE | E_BLK,
      CSQ | DSQ | U_REN | X_RD | E_SQ,
      E_BLK,               U_EXE | B_CMT | E_BLK,
      U_CMT | E_RUN
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NT-1:0]    thread_active = '1;
   logic             ctx_switch_stall = 1'b0;
   logic [NT*NS-1:0] stall_set = '0, stall_clr = '0;
   logic [NT-1:0]    commit_squash = '0, rob_flushing = '0, decode_squash = '0;
   logic [NT*PW-1:0] commit_pc = '0, decode_pc = '0;
   logic [NT-1:0]    line_fill = '0, fetch_go = '0, req_sent = '0, req_nack = '0;
   logic [NT-1:0]    retry_sent = '0, fetch_fault = '0, quiesce_hit = '0;
   logic [NT*4-1:0]  thread_state;
   logic [NT-1:0]    state_changed, redirect_valid, redirect_from_commit;
   logic [NT*PW-1:0] redirect_pc;
   logic             stage_active;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fetch_status_ctrl uut (
      .clk(clk), .rst_n(rst_n), .thread_active(thread_active),
      .ctx_switch_stall(ctx_switch_stall), .stall_set(stall_set), .stall_clr(stall_clr),
      .commit_squash(commit_squash), .commit_pc(commit_pc), .rob_flushing(rob_flushing),
      .decode_squash(decode_squash), .decode_pc(decode_pc), .line_fill(line_fill),
      .fetch_go(fetch_go), .req_sent(req_sent), .req_nack(req_nack),
      .retry_sent(retry_sent), .fetch_fault(fetch_fault), .quiesce_hit(quiesce_hit),
      .thread_state(thread_state), .state_changed(state_changed),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .redirect_from_commit(redirect_from_commit), .stage_active(stage_active)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic clear_inputs();
      stall_set = '0; stall_clr = '0; commit_squash = '0; rob_flushing = '0;
      decode_squash = '0; line_fill = '0; fetch_go = '0; req_sent = '0;
      req_nack = '0; retry_sent = '0; fetch_fault = '0; quiesce_hit = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic string tag_of(input logic [22:0] v);
      if (v[13])                   return "R3";
      if (v[12])                   return "R4";
      if (v[11])                   return "R5";
      if (v[10])                   return "R8";
      if (v[5] || v[4])            return "R10";
      if (v[17:14] != 0)           return "R2";
      if (v[21:18] != 0)           return "R6";
      if (v[9:6] != 0)             return "R9";
      return "R7";
   endfunction

   initial begin
      logic [3:0] prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "state", thread_state, '0);
      chk("R1", "changed", state_changed, '0);
      chk("R1", "redirect", redirect_valid, '0);
      chk("R1", "active", stage_active, 1'b1);

      prev = 4'd0;
      for (int i = 0; i < NV; i++) begin
         logic [22:0] v;
         v = VECS[i];
         stall_set[3:0]   = v[21:18];
         stall_clr[3:0]   = v[17:14];
         commit_squash[0] = v[13];
         rob_flushing[0]  = v[12];
         decode_squash[0] = v[11];
         line_fill[0]     = v[10];
         fetch_go[0]      = v[9];
         req_sent[0]      = v[8];
         req_nack[0]      = v[7];
         retry_sent[0]    = v[6];
         fetch_fault[0]   = v[5];
         quiesce_hit[0]   = v[4];
         commit_pc[PW-1:0] = 32'h1000_0000 + 32'(i * 16);
         decode_pc[PW-1:0] = 32'h8000_0000 + 32'(i * 16);
         tick();
         chk(tag_of(v), $sformatf("vec%0d state", i), thread_state[3:0], v[3:0]);
         chk("R12", $sformatf("vec%0d changed", i), state_changed[0], v[3:0] != prev);
         chk(tag_of(v), $sformatf("vec%0d redirect", i), redirect_valid[0], v[22]);
         if (v[22]) begin
            chk(tag_of(v), $sformatf("vec%0d pc", i), redirect_pc[PW-1:0],
                v[13] ? 32'h1000_0000 + 32'(i * 16) : 32'h8000_0000 + 32'(i * 16));
            chk(tag_of(v), $sformatf("vec%0d source", i), redirect_from_commit[0], v[13]);
         end
         chk("R3", $sformatf("vec%0d other thread", i), thread_state[7:4], 4'd0);
         prev = v[3:0];
         clear_inputs();
      end

      // R6 R11: context switch blocks both threads, stage goes idle
      ctx_switch_stall = 1'b1;
      tick();
      chk("R6", "ctx blocks", thread_state, 8'h33);
      chk("R11", "all blocked", stage_active, 1'b0);
      // R7 R11: release
      ctx_switch_stall = 1'b0;
      tick();
      chk("R7", "ctx release", thread_state, 8'h00);
      chk("R11", "running again", stage_active, 1'b1);
      // R11: only thread 0 participates, and it waits on the cache
      thread_active = 2'b01;
      req_sent[0] = 1'b1;
      tick();
      clear_inputs();
      chk("R9", "t0 waits", thread_state[3:0], 4'd6);
      chk("R11", "masked thread", stage_active, 1'b0);
      // R6: waiting thread keeps its state under the global stall
      thread_active = 2'b11;
      ctx_switch_stall = 1'b1;
      tick();
      chk("R6", "wait kept", thread_state, 8'h36);
      chk("R11", "blocked and waiting", stage_active, 1'b0);
      // R8: fill on thread 0 completes, stray fill on thread 1 ignored
      ctx_switch_stall = 1'b0;
      line_fill = 2'b11;
      tick();
      clear_inputs();
      chk("R8", "fill and stray", thread_state, 8'h08);
      chk("R11", "line ready", stage_active, 1'b1);
      // R3 R5: simultaneous redirects on different threads
      commit_squash[1] = 1'b1;
      commit_pc[2*PW-1:PW] = 32'hCAFE_0000;
      decode_squash[0] = 1'b1;
      decode_pc[PW-1:0] = 32'h0BAD_0040;
      tick();
      clear_inputs();
      chk("R3", "t1 squash", thread_state[7:4], 4'd2);
      chk("R3", "t1 pc", redirect_pc[2*PW-1:PW], 32'hCAFE_0000);
      chk("R3", "t1 source", redirect_from_commit[1], 1'b1);
      chk("R5", "t0 pc", redirect_pc[PW-1:0], 32'h0BAD_0040);
      chk("R5", "t0 source", redirect_from_commit[0], 1'b0);
      chk("R12", "both changed", state_changed, 2'b11);
      tick();
      chk("R7", "both resume", thread_state, 8'h00);
      chk("R5", "redirect drops", redirect_valid, 2'b00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule